// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit general-register operand into an IEEE 754 value ready to be written into a 64-bit floating-point register. A 2-bit source-type field selects one of four source formats. The source is signed or unsigned, and it is taken either from the low 32 bits or from the full 64 bits of the operand. A precision select picks a double-precision or a single-precision result. A single-precision result is rounded to single and then handed back re-encoded in double format, so the register file always receives double-format bits.

The conversion is one registered stage. Operands presented with `in_valid` appear on the outputs one clock later. The outputs hold their value until the next accepted operand. Alongside the result, the block reports four things: whether the rounded magnitude was bumped up, whether the result is inexact, an inexact-exception request, and a 5-bit result class code. It also gives a write strobe that tells the surrounding pipeline whether the status fields should be written at all.

A 32-bit integer converted to double precision can always be represented exactly. That path produces no status and leaves the status register alone. Every other combination rounds under the selected rounding mode and updates status.

Top module: `int2fp_convert`

## Requirements
- R1: Outputs change only on the clock edge that accepts an operand with `in_valid` high. `out_valid` is `in_valid` delayed by one cycle, and the result and flags hold while `in_valid` is low.
- R2: Source-type encoding is 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For the two 32-bit types, bits 63:32 of the operand have no effect on any output.
- R3: A 32-bit source converted to double precision gives the exact value, with `out_status_wr` low and `out_round_up`, `out_inexact` and `out_inexact_req` all low.
- R4: All other source/precision combinations round to the target precision under `in_rmode`, with 00 = nearest-even, 01 = toward zero, 10 = toward +infinity and 11 = toward -infinity. `out_status_wr` is high for these combinations.
- R5: `out_round_up` is high when the rounded magnitude exceeds the exact magnitude, and `out_inexact` is high when the rounded value differs from the exact value. `out_inexact_req` is high whenever `out_inexact` is high.
- R6: With `in_single` high, the value is rounded to a 24-bit significand and delivered in double encoding: single exponent re-biased to double, and fraction bits 28:0 equal to zero.
- R7: The class code is 5'b00010 for +0, 5'b00100 for a positive normal value and 5'b01000 for a negative normal value, taken from the rounded value at the target precision.
- R8: A zero operand of any type and precision gives all-zero result bits (+0.0) with the +0 class code.
- R9: The most negative signed value of each width converts exactly in both precisions: -2^63 gives 64'hC3E0000000000000 and -2^31 gives 64'hC1E0000000000000, with `out_inexact` low.
- R10: After reset, `out_valid`, `out_result`, `out_round_up`, `out_inexact`, `out_inexact_req`, `out_class` and `out_status_wr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand accepted on this edge |
| in_operand | input | 64 | Integer source operand |
| in_src_type | input | 2 | Source format (R2 encoding) |
| in_single | input | 1 | 1 = single-precision result, 0 = double |
| in_rmode | input | 2 | Rounding mode (R4 encoding) |
| out_valid | output | 1 | Result registered from an accepted operand |
| out_result | output | 64 | Double-format result bits |
| out_round_up | output | 1 | Rounded magnitude was incremented |
| out_inexact | output | 1 | Result is inexact |
| out_inexact_req | output | 1 | Inexact exception request |
| out_class | output | 5 | Result class code (R7) |
| out_status_wr | output | 1 | Status fields are to be written |

## Verification
The hardest case to reach from the ports is the round-up that ripples through an all-ones significand. This carry bumps the exponent, and it occurs only for operands whose top 53 (or 24) significant bits are all ones and whose discarded bits are non-zero. Uniform random operands almost never produce it. The stimulus therefore drives it directly: the unsigned 64-bit all-ones operand, and 2^24-1 shifted above the single-precision boundary, under every rounding mode. Exact ties are also built on purpose, as 2^53+1 and 2^53+3, to separate the even and odd cases of nearest-even rounding. Expected values come from a model that uses integer ulp arithmetic and an exact real-number encoding.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  localparam int XLEN    = 64;
  localparam int DP_MANT = 53;
  localparam int SP_MANT = 24;
  localparam int DP_EXPW = 11;
  localparam int SP_EXPW = 8;
  localparam int DP_BIAS = 1023;
  localparam int SP_BIAS = 127;
  localparam int POS_W   = $clog2(XLEN);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    SRC_S32 = 2'd0,
    SRC_U32 = 2'd1,
    SRC_S64 = 2'd2,
    SRC_U64 = 2'd3
  } src_e;

  localparam logic [4:0] CLS_PZERO = 5'b00010;
  localparam logic [4:0] CLS_PNORM = 5'b00100;
  localparam logic [4:0] CLS_NNORM = 5'b01000;

  // Re-encode a single-precision pattern in double format
  function automatic logic [63:0] widen_single(input logic [31:0] s);
    logic [DP_EXPW-1:0] e;
    if (s[30:0] == 31'd0) begin
      return {s[31], 63'd0};
    end
    e = DP_EXPW'(s[30:23]) + DP_EXPW'(DP_BIAS - SP_BIAS);
    return {s[31], e, s[22:0], 29'd0};
  endfunction

  function automatic logic [4:0] classify(input logic neg, input logic is_zero);
    if (is_zero)  return CLS_PZERO;
    else if (neg) return CLS_NNORM;
    else          return CLS_PNORM;
  endfunction

endpackage

// File: rtl/i2f_source.sv
module i2f_source #(
  parameter int W = 64
) (
  input  logic [W-1:0] opnd,
  input  logic [1:0]   src_type,
  output logic         neg,
  output logic [W-1:0] mag,
  output logic         narrow
);
  localparam int HW = W / 2;

  logic         is_signed;
  logic [W-1:0] val;

  always_comb begin
    narrow    = ~src_type[1];
    is_signed = ~src_type[0];
    if (narrow) begin
      if (is_signed) val = {{HW{opnd[HW-1]}}, opnd[HW-1:0]};
      else           val = {{HW{1'b0}}, opnd[HW-1:0]};
    end else begin
      val = opnd;
    end
    neg = is_signed & val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  mag,
  output logic [W-1:0]  norm,
  output logic [PW-1:0] top_pos,
  output logic          is_zero
);
  always_comb begin
    top_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) top_pos = PW'(i);
    end
    is_zero = ~|mag;
    norm    = mag << (PW'(W - 1) - top_pos);
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round #(
  parameter int W  = 64,
  parameter int MW = 53
) (
  input  logic [W-1:0]  norm,
  input  logic          neg,
  input  logic [1:0]    rmode,
  output logic [MW-2:0] frac,
  output logic          carry,
  output logic          inc,
  output logic          inexact
);
  import i2f_pkg::*;

  localparam int LW = W - MW;

  logic [MW-1:0] keep;
  logic          guard;
  logic          sticky;
  logic [MW:0]   sum;

  always_comb begin
    keep    = norm[W-1 -: MW];
    guard   = norm[LW-1];
    sticky  = |norm[LW-2:0];
    inexact = guard | sticky;
    case (rmode_e'(rmode))
      RM_NEAR: inc = guard & (sticky | keep[0]);
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = inexact & ~neg;
      default: inc = inexact & neg;
    endcase
    sum   = {1'b0, keep} + (MW+1)'(inc);
    carry = sum[MW];
    frac  = sum[MW-2:0];
  end
endmodule

// File: rtl/int2fp_convert.sv
module int2fp_convert (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  input  logic [1:0]  in_src_type,
  input  logic        in_single,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic        out_round_up,
  output logic        out_inexact,
  output logic        out_inexact_req,
  output logic [4:0]  out_class,
  output logic        out_status_wr
);
  import i2f_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // datapath
  logic             neg;
  logic [XLEN-1:0]  mag;
  logic             narrow;
  logic [XLEN-1:0]  norm;
  logic [POS_W-1:0] top_pos;
  logic             is_zero;

  i2f_source #(.W(XLEN)) src_i (
    .opnd(in_operand), .src_type(in_src_type),
    .neg(neg), .mag(mag), .narrow(narrow)
  );

  i2f_normalize #(.W(XLEN), .PW(POS_W)) nrm_i (
    .mag(mag), .norm(norm), .top_pos(top_pos), .is_zero(is_zero)
  );

  logic [DP_MANT-2:0] d_frac;
  logic               d_carry, d_inc, d_inx;
  logic [SP_MANT-2:0] s_frac;
  logic               s_carry, s_inc, s_inx;

  i2f_round #(.W(XLEN), .MW(DP_MANT)) rnd_dp_i (
    .norm(norm), .neg(neg), .rmode(in_rmode),
    .frac(d_frac), .carry(d_carry), .inc(d_inc), .inexact(d_inx)
  );

  i2f_round #(.W(XLEN), .MW(SP_MANT)) rnd_sp_i (
    .norm(norm), .neg(neg), .rmode(in_rmode),
    .frac(s_frac), .carry(s_carry), .inc(s_inc), .inexact(s_inx)
  );

  logic [DP_EXPW-1:0] d_exp;
  logic [SP_EXPW-1:0] s_exp;
  logic [63:0]        d_bits;
  logic [31:0]        s_bits;
  logic [63:0]        res_d;
  logic               stat_d;
  logic               inc_d, inx_d;
  logic [4:0]         cls_d;

  always_comb begin
    d_exp  = DP_EXPW'(DP_BIAS) + DP_EXPW'(top_pos) + DP_EXPW'(d_carry);
    s_exp  = SP_EXPW'(SP_BIAS) + SP_EXPW'(top_pos) + SP_EXPW'(s_carry);
    d_bits = is_zero ? 64'd0 : {neg, d_exp, d_frac};
    s_bits = is_zero ? 32'd0 : {neg, s_exp, s_frac};
    stat_d = ~(narrow & ~in_single);
    if (in_single) begin
      res_d = widen_single(s_bits);
      inc_d = s_inc;
      inx_d = s_inx;
      cls_d = classify(s_bits[31], s_bits[30:0] == 31'd0);
    end else begin
      res_d = d_bits;
      inc_d = d_inc;
      inx_d = d_inx;
      cls_d = classify(d_bits[63], d_bits[62:0] == 63'd0);
    end
  end

  // output register stage, enabled by in_valid
  logic        valid_q;
  logic [63:0] res_q;
  logic        up_q, inx_q, stat_q;
  logic [4:0]  cls_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      res_q   <= 64'd0;
      up_q    <= 1'b0;
      inx_q   <= 1'b0;
      cls_q   <= 5'd0;
      stat_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        up_q   <= stat_d & inc_d;
        inx_q  <= stat_d & inx_d;
        cls_q  <= cls_d;
        stat_q <= stat_d;
      end
    end
  end

  assign out_valid       = valid_q;
  assign out_result      = res_q;
  assign out_round_up    = up_q;
  assign out_inexact     = inx_q;
  assign out_inexact_req = inx_q;
  assign out_class       = cls_q;
  assign out_status_wr   = stat_q;
endmodule

// File: rtl/int2fp_convert_chk.sv
module int2fp_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_src_type,
  input logic        in_single,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_round_up,
  input logic        out_inexact,
  input logic        out_inexact_req,
  input logic [4:0]  out_class,
  input logic        out_status_wr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R1
  AST_NARROW_DOUBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_src_type[1] && !in_single) |=> !out_status_wr); // R3
  AST_EXACT_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_status_wr) |-> (!out_round_up && !out_inexact)); // R3
  AST_ROUNDING_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_src_type[1] || in_single)) |=> out_status_wr); // R4
  AST_UP_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_round_up |-> out_inexact); // R5
  AST_INEXACT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_inexact |-> out_inexact_req); // R5
  AST_SINGLE_PADDING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_single) |=> (out_result[28:0] == 29'd0)); // R6
  AST_SIGN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[63]) |-> (out_class == 5'b01000)); // R7
  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 5'b00010) |-> (out_result == 64'd0)); // R8
endmodule

bind int2fp_convert int2fp_convert_chk chk_i (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .in_src_type(in_src_type),
  .in_single(in_single), .out_valid(out_valid), .out_result(out_result),
  .out_round_up(out_round_up), .out_inexact(out_inexact),
  .out_inexact_req(out_inexact_req), .out_class(out_class),
  .out_status_wr(out_status_wr)
);

// File: tb/int2fp_convert_tb_top.sv
`timescale 1ns/1ps
module int2fp_convert_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_operand;
  logic [1:0]  in_src_type;
  logic        in_single;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_round_up, out_inexact, out_inexact_req, out_status_wr;
  logic [4:0]  out_class;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  int2fp_convert dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_src_type(in_src_type), .in_single(in_single), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result), .out_round_up(out_round_up),
    .out_inexact(out_inexact), .out_inexact_req(out_inexact_req),
    .out_class(out_class), .out_status_wr(out_status_wr)
  );

  task automatic expect_val(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one operand and compare every output against the model
  task automatic convert_check(input logic [63:0] op, input logic [1:0] st,
                               input logic sp, input logic [1:0] rm, input string req);
    logic [63:0] v, m;
    logic        ng, bumped, exact_path;
    logic [64:0] ulp, t, rem, half, pick;
    int          nb, prec;
    real         r;
    logic [63:0] e_res;
    logic [4:0]  e_cls;
    string       freq;
    case (st)
      2'd0: begin v = {{32{op[31]}}, op[31:0]}; ng = op[31]; end
      2'd1: begin v = {32'd0, op[31:0]}; ng = 1'b0; end
      2'd2: begin v = op; ng = op[63]; end
      default: begin v = op; ng = 1'b0; end
    endcase
    m  = ng ? (64'd0 - v) : v;
    nb = 0;
    for (int i = 0; i < 64; i++) if (m[i]) nb = i + 1;
    prec   = sp ? 24 : 53;
    bumped = 1'b0;
    rem    = 65'd0;
    if (nb <= prec) begin
      pick = {1'b0, m};
    end else begin
      ulp  = 65'd1 << (nb - prec);
      t    = {1'b0, m} & ~(ulp - 65'd1);
      rem  = {1'b0, m} & (ulp - 65'd1);
      half = ulp >> 1;
      case (rm)
        2'b00: bumped = (rem > half) || (rem == half && (t & ulp) != 65'd0);
        2'b01: bumped = 1'b0;
        2'b10: bumped = (rem != 65'd0) && !ng;
        default: bumped = (rem != 65'd0) && ng;
      endcase
      pick = bumped ? t + ulp : t;
    end
    r = real'(pick[64:32]) * 4294967296.0 + real'(pick[31:0]);
    if (ng) r = -r;
    e_res      = (pick == 65'd0) ? 64'd0 : $realtobits(r);
    e_cls      = (pick == 65'd0) ? 5'b00010 : (ng ? 5'b01000 : 5'b00100);
    exact_path = !st[1] && !sp;
    freq       = exact_path ? "R3" : "R5";

    @(negedge clk);
    in_operand = op; in_src_type = st; in_single = sp; in_rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_val("R1", "valid", 64'(out_valid), 64'd1);
    expect_val(req, "result", out_result, e_res);
    expect_val("R7", "class", 64'(out_class), 64'(e_cls));
    expect_val(exact_path ? "R3" : "R4", "status_wr", 64'(out_status_wr), 64'(!exact_path));
    expect_val(freq, "flags up/inexact/req",
               {61'd0, out_round_up, out_inexact, out_inexact_req},
               {61'd0, !exact_path && bumped, !exact_path && rem != 0, !exact_path && rem != 0});
  endtask

  task automatic t_reset;
    expect_val("R10", "valid", 64'(out_valid), 64'd0);
    expect_val("R10", "result", out_result, 64'd0);
    expect_val("R10", "flags", {58'd0, out_round_up, out_inexact, out_inexact_req, out_status_wr, out_class[1:0]}, 64'd0);
    expect_val("R10", "class", 64'(out_class), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] kept;
    convert_check(64'd12345, 2'd2, 1'b0, 2'b00, "R1");
    kept = out_result;
    @(negedge clk);
    in_operand = 64'hFFFF_0000_1234_5678; in_src_type = 2'd3; in_single = 1'b1;
    repeat (3) @(negedge clk);
    expect_val("R1", "held result", out_result, kept);
    expect_val("R1", "valid low", 64'(out_valid), 64'd0);
  endtask

  task automatic t_upper_ignored;
    for (int s = 0; s < 2; s++) begin
      convert_check(64'hDEAD_BEEF_0000_0005, 2'(s), 1'b0, 2'b00, "R2");
      expect_val("R2", "five", out_result, 64'h4014_0000_0000_0000);
    end
    convert_check(64'h1234_5678_FFFF_FFFF, 2'd0, 1'b0, 2'b00, "R2");
    expect_val("R2", "minus one", out_result, 64'hBFF0_0000_0000_0000);
    convert_check(64'h1234_5678_FFFF_FFFF, 2'd1, 1'b1, 2'b10, "R2");
  endtask

  task automatic t_exact32;
    for (int rm = 0; rm < 4; rm++) begin
      convert_check(64'h0000_0000_7FFF_FFFF, 2'd0, 1'b0, 2'(rm), "R3");
      convert_check(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, 2'(rm), "R3");
      convert_check(64'h0000_0000_8000_0001, 2'd0, 1'b0, 2'(rm), "R3");
    end
  endtask

  task automatic t_rounding;
    for (int rm = 0; rm < 4; rm++) begin
      convert_check(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'(rm), "R4");
      convert_check(64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'(rm), "R4");
      convert_check(64'hFFDF_FFFF_FFFF_FFFD, 2'd2, 1'b0, 2'(rm), "R4");
      convert_check(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'(rm), "R4");
      convert_check(64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'(rm), "R5");
    end
  endtask

  task automatic t_single;
    for (int rm = 0; rm < 4; rm++) begin
      convert_check(64'd16777217, 2'd0, 1'b1, 2'(rm), "R6");
      convert_check(64'd16777219, 2'd1, 1'b1, 2'(rm), "R6");
      convert_check(64'h0000_0000_FFFF_FFFF, 2'd1, 1'b1, 2'(rm), "R6");
      convert_check(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'(rm), "R6");
      convert_check(64'hFFFF_FFFF_FF00_0001, 2'd2, 1'b1, 2'(rm), "R6");
    end
    convert_check(64'd3, 2'd1, 1'b1, 2'b00, "R6");
    expect_val("R6", "three single", out_result, 64'h4008_0000_0000_0000);
  endtask

  task automatic t_zero;
    for (int st = 0; st < 4; st++) begin
      convert_check(64'h0, 2'(st), 1'b0, 2'b11, "R8");
      convert_check(64'hABCD_0000_0000_0000 & {64{st < 2}}, 2'(st), 1'b1, 2'b11, "R8");
      expect_val("R8", "zero bits", out_result, 64'd0);
      expect_val("R8", "zero class", 64'(out_class), 64'b00010);
    end
  endtask

  task automatic t_minneg;
    for (int sp = 0; sp < 2; sp++) begin
      convert_check(64'h8000_0000_0000_0000, 2'd2, 1'(sp), 2'b00, "R9");
      expect_val("R9", "min s64", out_result, 64'hC3E0_0000_0000_0000);
      expect_val("R9", "min s64 exact", 64'(out_inexact), 64'd0);
      convert_check(64'h0000_0000_8000_0000, 2'd0, 1'(sp), 2'b10, "R9");
      expect_val("R9", "min s32", out_result, 64'hC1E0_0000_0000_0000);
      expect_val("R9", "min s32 exact", 64'(out_inexact), 64'd0);
    end
  endtask

  task automatic t_random;
    logic [63:0] op;
    for (int k = 0; k < 400; k++) begin
      op = {$urandom, $urandom} >> ($urandom % 64);
      convert_check(op, 2'($urandom), 1'($urandom), 2'($urandom), "R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_operand = 64'd0;
    in_src_type = 2'd0; in_single = 1'b0; in_rmode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold();
    t_upper_ignored();
    t_exact32();
    t_rounding();
    t_single();
    t_zero();
    t_minneg();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule